// File: doc/BRIEF.md
# I2C Slave Register Interface

This block lets an external I2C master read and write a small array of byte-wide registers inside the chip. SCL and SDA are sampled by the system clock through a short synchronizer. START and STOP are found from those samples, and every bus event becomes a single-cycle strobe that drives a byte-level state machine.

A transaction opens with a device address byte that carries a fixed 7-bit identifier and a read/write flag. A write then sends a register address byte and one or more data bytes, and the register pointer advances after each data byte. A read returns bytes from the current pointer, most significant bit first, for as long as the master acknowledges. The SDA pad is open-drain. The block only signals when it pulls the line low; the pad and the pull-up are outside it.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is asserted, and directly after it, sda_oe_o is 0. A START plus address byte sent during reset gets no acknowledge. All eight registers read back as 0x00 after reset.
- R2: Before a START (SDA falling while SCL is high) has been seen, clocked bytes are ignored and never acknowledged, even the matching address byte 0x88.
- R3: The first byte after START is matched in bits 7:1 against identifier 7'b1000100. A match is acknowledged by holding SDA low during the ninth SCL high phase. A mismatch (for example 0x8A) gets no acknowledge, and every later byte is ignored until the next START.
- R4: In a write (bit 0 = 0), the register address byte is acknowledged and its low 3 bits load the pointer. Each data byte is acknowledged and stored at the pointer when its ninth SCL clock falls.
- R5: After each stored write byte the pointer advances by one, and from register 7 it wraps to register 0.
- R6: A STOP (SDA rising while SCL is high) in the middle of a data byte ends the transaction, and the partial byte is not stored. A byte that finished together with its acknowledge before the STOP stays stored.
- R7: In a read (address byte 0x89, usually after a repeated START), the slave sends the register at the pointer MSB first. It pulls SDA low for a 0 bit and releases it for a 1 bit.
- R8: After each read byte the pointer advances, with the same 7-to-0 wrap. A master ACK (SDA low on the ninth clock) starts the next byte. A NACK makes the slave release SDA and return to idle.
- R9: A read that does not set the pointer first starts at the register after the last one written or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
In a burst write that runs through register 7, the commit of the data byte into register 7 and the pointer wrap to 0 fall on the same clock edge. The bench sets this up on purpose with a burst that starts at register 6, and random bursts reach it again. The result is judged by reading back every register the burst touched against a model array kept in the bench. A second collision is a STOP that lands next to a byte boundary. It is forced with a STOP after part of a byte that follows a complete, acknowledged byte, and the bench reads back to confirm that only the complete byte was stored.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } link_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PW = STAGES + 1;

  logic [PW-1:0] scl_pipe, sda_pipe;
  logic scl_cur, scl_prev, sda_cur, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PW-2:0], scl_i};
      sda_pipe <= {sda_pipe[PW-2:0], sda_i};
    end
  end

  assign scl_cur  = scl_pipe[STAGES-1];
  assign scl_prev = scl_pipe[STAGES];
  assign sda_cur  = sda_pipe[STAGES-1];
  assign sda_prev = sda_pipe[STAGES];

  assign sda_s     = sda_cur;
  assign scl_rise  = scl_cur & ~scl_prev;
  assign scl_fall  = ~scl_cur & scl_prev;
  assign start_det = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_det  = scl_cur & scl_prev & ~sda_prev & sda_cur;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WIDTH-1:0]         rd_data
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (sel) begin
        mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];

  // R4
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/i2c_link_ctrl.sv
module i2c_link_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'b1000100,
  parameter int         DEPTH  = 8,
  parameter int         DW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sda_s,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic [DW-1:0]            rd_data,
  output logic                     sda_oe,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [DW-1:0]            wr_data,
  output logic [$clog2(DEPTH)-1:0] rd_addr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DW + 1);

  link_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          oe_q, oe_d;
  logic          rw_q, rw_d;
  logic          mack_q, mack_d;
  logic          bus_evt;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign bus_evt = start_det | stop_det;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    wr_en   = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_REG, ST_WR: begin
          if (scl_rise && cnt_q != CW'(DW)) begin
            sh_d  = {sh_q[DW-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == CW'(DW)) begin
            cnt_d = '0;
            oe_d  = 1'b1;
            if (state_q == ST_DEV) begin
              if (sh_q[DW-1:1] == DEV_ID) begin
                state_d = ST_DEV_ACK;
                rw_d    = sh_q[0];
              end else begin
                state_d = ST_IDLE;
                oe_d    = 1'b0;
              end
            end else if (state_q == ST_REG) begin
              state_d = ST_REG_ACK;
            end else begin
              state_d = ST_WR_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_RD;
              sh_d    = rd_data;
              oe_d    = ~rd_data[DW-1];
            end else begin
              state_d = ST_REG;
              oe_d    = 1'b0;
            end
          end
        end
        ST_REG_ACK: begin
          if (scl_fall) begin
            ptr_d   = sh_q[AW-1:0];
            state_d = ST_WR;
            oe_d    = 1'b0;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            wr_en   = 1'b1;
            ptr_d   = ptr_next(ptr_q);
            state_d = ST_WR;
            oe_d    = 1'b0;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == CW'(DW - 1)) begin
              cnt_d   = '0;
              oe_d    = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              cnt_d = cnt_q + 1'b1;
              sh_d  = {sh_q[DW-2:0], 1'b0};
              oe_d  = ~sh_q[DW-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end
          if (scl_fall) begin
            ptr_d = ptr_next(ptr_q);
            if (mack_q) begin
              state_d = ST_RD;
              sh_d    = rd_data;
              oe_d    = ~rd_data[DW-1];
              cnt_d   = '0;
            end else begin
              state_d = ST_IDLE;
              oe_d    = 1'b0;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_addr = ptr_q;
  assign wr_data = sh_q;
  assign rd_addr = (state_q == ST_RD_ACK) ? ptr_next(ptr_q) : ptr_q;

  // R3
  drive_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (state_q inside {ST_DEV_ACK, ST_REG_ACK, ST_WR_ACK, ST_RD}));

  // R3
  id_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEV && scl_fall && !bus_evt && cnt_q == CW'(DW) &&
     sh_q[DW-1:1] != DEV_ID) |=> (state_q == ST_IDLE && !oe_q));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR_ACK && scl_fall && !bus_evt && ptr_q == AW'(DEPTH - 1))
      |=> ptr_q == '0);

  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !oe_q));

  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK && scl_fall && !bus_evt && !mack_q)
      |=> (state_q == ST_IDLE && !oe_q));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ID      = 7'b1000100,
  parameter int         REG_DEPTH   = 8,
  parameter int         REG_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int AW = $clog2(REG_DEPTH);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [REG_W-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_link_ctrl #(.DEV_ID(DEV_ID), .DEPTH(REG_DEPTH), .DW(REG_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr)
  );

  i2c_reg_bank #(.DEPTH(REG_DEPTH), .WIDTH(REG_W)) bank_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> !sda_oe_o);
endmodule

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic scl_m, sda_m;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_slave dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] model [8];
  int mptr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input bit b);
    sda_m = b;    wq(Q);
    scl_m = 1'b1; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q / 2);
    acked = !sda_line;
    wq(Q / 2);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q / 2);
      b[i] = sda_line;
      wq(Q / 2);
      scl_m = 1'b0;
    end
    sda_m = !give_ack; wq(Q);
    scl_m = 1'b1;      wq(Q);
    scl_m = 1'b0;      wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_seq(input int addr, input int n);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(8'h88, a); chk(a, "R3 id ack", a, 1);
    send_byte(8'(addr), a); chk(a, "R4 reg addr ack", a, 1);
    mptr = addr % 8;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, a); chk(a, "R4 data ack", a, 1);
      model[mptr] = d;
      mptr = (mptr + 1) % 8;
    end
    bus_stop();
  endtask

  task automatic read_seq(input int addr, input bit set_addr, input int n, input string tag);
    bit a;
    logic [7:0] b;
    bus_start();
    if (set_addr) begin
      send_byte(8'h88, a); chk(a, "R3 id ack", a, 1);
      send_byte(8'(addr), a); chk(a, "R4 reg addr ack", a, 1);
      mptr = addr % 8;
      bus_start();
    end
    send_byte(8'h89, a); chk(a, "R3 read id ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k != n - 1);
      chk(b == model[mptr], tag, b, model[mptr]);
      mptr = (mptr + 1) % 8;
    end
    wq(2);
    chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] d;
    void'($urandom(32'h1c2d));
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    wq(4);
    chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    bus_start();
    send_byte(8'h88, a); chk(!a, "R1 start in reset ignored", a, 0);
    bus_stop();
    rst_n = 1'b1;
    wq(8);
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    read_seq(0, 1'b1, 8, "R1 reset contents");

    // R2: bytes without a START
    send_byte(8'h88, a); chk(!a, "R2 no start no ack", a, 0);
    bus_stop();

    // R3: identifier mismatch, then a following byte
    bus_start();
    send_byte(8'h8A, a); chk(!a, "R3 wrong id nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R3 ignored after miss", a, 0);
    bus_stop();

    // R4 / R7
    write_seq(2, 1);
    read_seq(2, 1'b1, 1, "R7 single readback");

    // R5: burst through the wrap
    write_seq(6, 4);
    read_seq(6, 1'b1, 4, "R5 wrap readback");

    // R6: STOP mid byte after one complete byte
    bus_start();
    send_byte(8'h88, a); chk(a, "R3 id ack", a, 1);
    send_byte(8'h05, a); chk(a, "R4 reg addr ack", a, 1);
    d = 8'hA5;
    send_byte(d, a); chk(a, "R4 data ack", a, 1);
    model[5] = d;
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_stop();
    read_seq(5, 1'b1, 2, "R6 partial byte discarded");

    // R6: STOP mid byte as first data byte
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h03, a);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_stop();
    read_seq(3, 1'b1, 1, "R6 register unchanged");

    // R9: read continues from pointer after write
    write_seq(4, 2);
    read_seq(0, 1'b0, 2, "R9 pointer after write");

    // R8: read with wrap
    read_seq(7, 1'b1, 3, "R8 read wrap");

    for (int it = 0; it < 12; it++) begin
      write_seq(int'($urandom % 8), 1 + int'($urandom % 6));
      read_seq(int'($urandom % 8), 1'($urandom % 2), 1 + int'($urandom % 8), "R7 random readback");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule